// File: doc/BRIEF.md
# CCCV Dual-Loop Current Setpoint Controller

This block computes the output current setpoint of a power converter that must hold either a current limit or a voltage limit, whichever binds first. Once per control tick it samples the measured output voltage, the filtered output current, the two limits, four gains and two integrator band thresholds. It then evaluates a voltage loop and a current loop side by side and registers the smaller of their two current requests as the new setpoint.

The voltage loop starts from the measured current and adds a proportional and an integral correction on the voltage error. The current loop starts from the current limit and adds its own proportional and integral correction on the current error. Each integrator accumulates only while its error is small. Outside that band it is cleared to zero, which keeps large steps from winding it up. All values are signed fixed-point. The gains carry 8 fraction bits, so a gain of 256 equals 1.0. Every intermediate result is saturated to the signed data width.

Top module: `cccv_setpoint`

## Requirements
- R1: A synchronous active-high reset drives the setpoint to 0 and valid to 0, and clears both integrators to 0.
- R2: When tick is high at a rising edge, the setpoint is updated at that edge. Valid is then high for exactly the one cycle that follows the next rising edge. Without a tick the setpoint holds its value.
- R3: Each loop computes its error as sat(limit − measured). Its proportional term is sat((error·Kp) >>> 8) and its integral increment is sat((error·Ki) >>> 8). The shift is arithmetic and rounds toward minus infinity.
- R4: The voltage request is sat(iMeas + voltage proportional term + updated voltage integrator).
- R5: The voltage integrator becomes sat(old + increment) when |voltage error| is strictly less than vBand. Otherwise it becomes 0, so an error equal to vBand clears it.
- R6: The current request is sat(iLimit + current proportional term + updated current integrator).
- R7: The current integrator is cleared to 0 when |current error| is greater than iBand. Otherwise it becomes sat(old + increment), so an error equal to iBand still accumulates.
- R8: The registered setpoint is the smaller of the two requests. A negative result is replaced by 0.
- R9: Every saturation clamps to the signed data width range, which is [−32768, 32767] at the default width of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle update request |
| vMeas | input | DW | Measured output voltage, signed |
| iMeas | input | DW | Filtered output current, signed |
| vLimit | input | DW | Voltage limit, signed |
| iLimit | input | DW | Current limit, signed |
| kpV | input | GW | Voltage loop proportional gain, signed, 8 fraction bits |
| kiV | input | GW | Voltage loop integral gain, signed, 8 fraction bits |
| kpI | input | GW | Current loop proportional gain, signed, 8 fraction bits |
| kiI | input | GW | Current loop integral gain, signed, 8 fraction bits |
| vBand | input | DW | Voltage integrator band threshold, unsigned |
| iBand | input | DW | Current integrator band threshold, unsigned |
| setpoint | output | DW | Registered current setpoint, signed and never negative |
| valid | output | 1 | Pulses one cycle after each setpoint update |

## Verification
A wrong integrator value is invisible until the next tick. That tick's setpoint then differs from the expected one by the stored error, and the difference grows on every later tick inside the band. Zeroing the proportional gains makes each setpoint equal to feedforward plus integrator, so the accumulation of each loop can be read directly at the setpoint port, including at the band edges. A mistake in the minimum selection, the clamp or the saturation shows up on the very update where the affected request would win. A mistake in the valid pipeline shows up two edges after the tick.

// File: rtl/cccv_pkg.sv
package cccv_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } ctrlStrobe_t;
endpackage

// File: rtl/cccv_pi_loop.sv
module cccv_pi_loop
  import cccv_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int GF = 8,
  parameter bit STRICT_BAND = 1'b1
) (
  input  logic                 clk,
  input  ctrlStrobe_t          strb,
  input  logic signed [DW-1:0] limit,
  input  logic signed [DW-1:0] meas,
  input  logic signed [DW-1:0] base,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  input  logic        [DW-1:0] thr,
  output logic signed [DW-1:0] req
);
  localparam int PW = DW + GW + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - 1;

  function automatic logic signed [DW-1:0] satW(input logic signed [PW-1:0] x);
    if (x > MAXV) return MAXV[DW-1:0];
    if (x < MINV) return MINV[DW-1:0];
    return x[DW-1:0];
  endfunction

  logic signed [DW-1:0] acc, accNext, err, pTerm, iInc;
  logic signed [PW-1:0] limX, measX, baseX, kpX, kiX, thrX, errX, absErr, accX;
  logic inBand;

  always_comb begin
    limX   = limit;
    measX  = meas;
    baseX  = base;
    kpX    = kp;
    kiX    = ki;
    thrX   = $signed({{(PW-DW){1'b0}}, thr});
    err    = satW(limX - measX);
    errX   = err;
    pTerm  = satW((errX * kpX) >>> GF);
    iInc   = satW((errX * kiX) >>> GF);
    absErr = (errX < 0) ? -errX : errX;
    if (STRICT_BAND) inBand = absErr < thrX;
    else             inBand = absErr <= thrX;
    accX   = acc;
    accNext = inBand ? satW(accX + PW'(iInc)) : '0;
    req    = satW(baseX + PW'(pTerm) + PW'(accNext));
  end

  always_ff @(posedge clk) begin
    if (strb.clear)     acc <= '0;
    else if (strb.load) acc <= accNext;
  end
endmodule

// File: rtl/cccv_ctrl.sv
module cccv_ctrl
  import cccv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  output ctrlStrobe_t strb,
  output logic        valid
);
  logic loadDly;

  always_comb begin
    strb.clear = rst;
    strb.load  = tick & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loadDly <= 1'b0;
      valid   <= 1'b0;
    end else begin
      loadDly <= strb.load;
      valid   <= loadDly;
    end
  end
endmodule

// File: rtl/cccv_datapath.sv
module cccv_datapath
  import cccv_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int GF = 8
) (
  input  logic                 clk,
  input  ctrlStrobe_t          strb,
  input  logic signed [DW-1:0] vMeas,
  input  logic signed [DW-1:0] iMeas,
  input  logic signed [DW-1:0] vLimit,
  input  logic signed [DW-1:0] iLimit,
  input  logic signed [GW-1:0] kpV,
  input  logic signed [GW-1:0] kiV,
  input  logic signed [GW-1:0] kpI,
  input  logic signed [GW-1:0] kiI,
  input  logic        [DW-1:0] vBand,
  input  logic        [DW-1:0] iBand,
  output logic signed [DW-1:0] setpoint
);
  logic signed [DW-1:0] reqV, reqI, pick, nextSp;

  cccv_pi_loop #(.DW(DW), .GW(GW), .GF(GF), .STRICT_BAND(1'b1)) u_vloop (
    .clk(clk), .strb(strb), .limit(vLimit), .meas(vMeas), .base(iMeas),
    .kp(kpV), .ki(kiV), .thr(vBand), .req(reqV)
  );

  cccv_pi_loop #(.DW(DW), .GW(GW), .GF(GF), .STRICT_BAND(1'b0)) u_iloop (
    .clk(clk), .strb(strb), .limit(iLimit), .meas(iMeas), .base(iLimit),
    .kp(kpI), .ki(kiI), .thr(iBand), .req(reqI)
  );

  always_comb begin
    pick   = (reqV < reqI) ? reqV : reqI;
    nextSp = (pick < 0) ? '0 : pick;
  end

  always_ff @(posedge clk) begin
    if (strb.clear)     setpoint <= '0;
    else if (strb.load) setpoint <= nextSp;
  end
endmodule

// File: rtl/cccv_setpoint.sv
module cccv_setpoint
  import cccv_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int GF = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic signed [DW-1:0] vMeas,
  input  logic signed [DW-1:0] iMeas,
  input  logic signed [DW-1:0] vLimit,
  input  logic signed [DW-1:0] iLimit,
  input  logic signed [GW-1:0] kpV,
  input  logic signed [GW-1:0] kiV,
  input  logic signed [GW-1:0] kpI,
  input  logic signed [GW-1:0] kiI,
  input  logic        [DW-1:0] vBand,
  input  logic        [DW-1:0] iBand,
  output logic signed [DW-1:0] setpoint,
  output logic                 valid
);
  ctrlStrobe_t strb;

  cccv_ctrl u_ctrl (.clk(clk), .rst(rst), .tick(tick), .strb(strb), .valid(valid));

  cccv_datapath #(.DW(DW), .GW(GW), .GF(GF)) u_dp (
    .clk(clk), .strb(strb), .vMeas(vMeas), .iMeas(iMeas), .vLimit(vLimit),
    .iLimit(iLimit), .kpV(kpV), .kiV(kiV), .kpI(kpI), .kiI(kiI),
    .vBand(vBand), .iBand(iBand), .setpoint(setpoint)
  );
endmodule

// File: rtl/cccv_setpoint_chk.sv
module cccv_setpoint_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick,
  input logic signed [DW-1:0] setpoint,
  input logic                 valid
);
  // R2: a tick produces valid two edges later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    tick |=> ##1 valid);
  // R2: no tick, no valid two edges later
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ##1 !valid);
  // R2: setpoint holds without a tick
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(setpoint));
  // R8: setpoint is never negative
  a_r8_nonneg: assert property (@(posedge clk) disable iff (rst)
    setpoint >= 0);
endmodule

bind cccv_setpoint cccv_setpoint_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .setpoint(setpoint), .valid(valid)
);

// File: tb/cccv_setpoint_tb.sv
module cccv_setpoint_tb;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic signed [15:0] vMeas = 0, iMeas = 0, vLimit = 0, iLimit = 0;
  logic signed [15:0] kpV = 0, kiV = 0, kpI = 0, kiI = 0;
  logic [15:0] vBand = 0, iBand = 0;
  logic signed [15:0] setpoint;
  logic valid;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  longint accV = 0, accI = 0, expSp = 0;

  always #2.5 clk = ~clk;

  cccv_setpoint u_dut (
    .clk(clk), .rst(rst), .tick(tick), .vMeas(vMeas), .iMeas(iMeas),
    .vLimit(vLimit), .iLimit(iLimit), .kpV(kpV), .kiV(kiV), .kpI(kpI),
    .kiI(kiI), .vBand(vBand), .iBand(iBand), .setpoint(setpoint), .valid(valid)
  );

  function automatic longint sat(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic longint absv(input longint x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // model one update; returns tag of the winning loop
  function automatic string model();
    longint eV, eI, pV, pI, nV, nI, rV, rI, m;
    eV = sat(longint'(vLimit) - longint'(vMeas));
    pV = sat((eV * longint'(kpV)) >>> 8);
    nV = (absv(eV) < longint'(vBand)) ? sat(accV + sat((eV * longint'(kiV)) >>> 8)) : 0;
    rV = sat(longint'(iMeas) + pV + nV);
    eI = sat(longint'(iLimit) - longint'(iMeas));
    pI = sat((eI * longint'(kpI)) >>> 8);
    nI = (absv(eI) > longint'(iBand)) ? 0 : sat(accI + sat((eI * longint'(kiI)) >>> 8));
    rI = sat(longint'(iLimit) + pI + nI);
    accV = nV;
    accI = nI;
    m = (rV < rI) ? rV : rI;
    expSp = (m < 0) ? 0 : m;
    if (m < 0) return "R8";
    return (rV < rI) ? "R4" : "R6";
  endfunction

  // called at a negedge with inputs already set
  task automatic doTick(input string tag);
    string t;
    t = model();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check((tag == "") ? t : tag, setpoint, expSp);
    check("R2 valid low after update edge", valid, 0);
    @(negedge clk);
    check("R2 valid high", valid, 1);
  endtask

  task automatic setIn(input longint vm, im, vl, il, kpv, kiv, kpi, kii, vb, ib);
    vMeas = 16'(vm); iMeas = 16'(im); vLimit = 16'(vl); iLimit = 16'(il);
    kpV = 16'(kpv); kiV = 16'(kiv); kpI = 16'(kpi); kiI = 16'(kii);
    vBand = 16'(vb); iBand = 16'(ib);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 setpoint at reset", setpoint, 0);
    check("R1 valid at reset", valid, 0);
    rst = 1'b0;
    @(negedge clk);

    // R5: error equal to band clears voltage integrator
    setIn(990, 100, 1000, 20000, 0, 256, 256, 0, 10, 0);
    doTick("R5 band edge clears");
    vBand = 11;
    doTick("R5 accumulate 1");
    doTick("R5 accumulate 2");
    check("R5 integrator value", setpoint, 120);

    // R2: hold without tick, valid falls
    @(negedge clk);
    check("R2 valid back low", valid, 0);
    vMeas = 0;
    repeat (3) @(negedge clk);
    check("R2 hold without tick", setpoint, 120);

    // R1: reset clears integrators
    rst = 1'b1;
    @(negedge clk);
    check("R1 setpoint after mid reset", setpoint, 0);
    check("R1 valid after mid reset", valid, 0);
    rst = 1'b0;
    accV = 0; accI = 0;
    setIn(990, 100, 1000, 20000, 0, 256, 256, 0, 11, 0);
    doTick("R1 integrator restarted");

    // R7: error equal to band still accumulates current integrator
    setIn(0, 490, 20000, 500, 256, 0, 0, 256, 0, 10);
    doTick("R7 band edge accumulates");
    doTick("R7 accumulate again");
    check("R7 integrator value", setpoint, 520);
    iBand = 9;
    doTick("R7 outside band clears");

    // R3: proportional with floor shift on negative error
    setIn(0, 103, 20000, 100, 256, 0, 384, 0, 0, 0);
    doTick("R3 floor shift");  // err -3 * 1.5 = -4.5 -> -5, req 95

    // R9: saturation everywhere
    setIn(-32768, 32767, 32767, 32767, 32767, 32767, 32767, 32767, 65535, 65535);
    doTick("R9 saturate high");

    // R8: negative clamps to zero
    accV = 0; accI = 0;
    setIn(0, 0, 20000, -100, 256, 0, 0, 0, 0, 0);
    doTick("R8 negative clamp");

    // random mix
    for (int n = 0; n < 300; n++) begin
      setIn($signed(16'($urandom_range(0, 8000))) - 4000,
            $signed(16'($urandom_range(0, 8000))) - 4000,
            $signed(16'($urandom_range(0, 8000))) - 4000,
            $signed(16'($urandom_range(0, 8000))) - 4000,
            $urandom_range(0, 1023), $urandom_range(0, 511),
            $urandom_range(0, 1023), $urandom_range(0, 511),
            $urandom_range(0, 2000), $urandom_range(0, 2000));
      if (n % 37 == 0) begin
        vLimit = 32767; vMeas = -32768; kpV = 16'sd32767;
      end
      doTick("");
    end
    finish();
  end
endmodule